// File: doc/BRIEF.md
# Byte-Wide Flash Program and Erase Sequencer

This block sits on the host side of a parallel byte-wide flash device. It takes one request at a time on a valid/ready command port: a byte program, a whole-chip erase, or an identification read. It turns each request into the multi-cycle write sequence the flash expects, made of unlock writes, a set-up byte and a command byte. Every write and read strobe on the bus is timed by clock-cycle counts set through parameters.

A program or erase does not end after a fixed wait. The sequencer reads the target address again and again and watches bit 7 of the returned byte. It finishes when that bit equals the true bit 7 of the expected contents. If bit 5 is reported high first, the sequencer reads once more. If that read still does not match, it sends the reset command and flags an error. An identification request puts the device into its identify mode, reads the manufacturer and device bytes, and then returns the device to normal reads.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` is a single-cycle pulse that ends every accepted request. After reset `req_ready`=1, `rsp_valid`=0 and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1.
- R2: A program request (`req_op`=0) writes four bytes in this order: AAh at UNLOCK_A1 (default 5555h), 55h at UNLOCK_A2 (default 2AAAh), A0h at UNLOCK_A1, then `req_data` at `req_addr`.
- R3: A chip erase request (`req_op`=1) writes six bytes in this order: AAh@A1, 55h@A2, 80h@A1, AAh@A1, 55h@A2, 10h@A1.
- R4: An identification request (`req_op`=2) writes AAh@A1, 55h@A2 and 90h@A1. It then reads address 0 and address 1, and writes F0h@A1. `rsp_id` returns {byte at 0, byte at 1} with `rsp_error`=0.
- R5: For each bus write, `fl_ce_n` is low and `fl_dq_oe` is high. Address and data stay stable while `fl_we_n` is high for T_SETUP cycles, then low for exactly T_WE cycles, then high again for T_HOLD cycles before `fl_ce_n` rises. `fl_we_n` and `fl_oe_n` are never low together.
- R6: After a program or erase sequence, the sequencer reads `req_addr` repeatedly. It stops at the first read whose bit 7 equals `req_data[7]` (program) or 1 (erase), then responds with `rsp_error`=0.
- R7: Suppose a polling read has bit 5 high and bit 7 does not match. The sequencer then makes exactly one more read of the same address. If that read matches, the response is a success. Otherwise it writes F0h@A1 and responds with `rsp_error`=1.
- R8: A request with `req_op`=3 is reserved. It produces a response with `rsp_error`=1 on the cycle after acceptance, and causes no bus cycle.
- R9: Each bus read keeps `fl_dq_oe` low, `fl_we_n` high and `fl_ce_n` low. It holds `fl_oe_n` low for exactly T_RD cycles and captures the data on the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 chip erase, 2 identify, 3 reserved |
| req_addr | input | ADDR_W | Target address for program and polling |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Operation failed or was reserved |
| rsp_id | output | 16 | Manufacturer byte (high) and device byte (low) |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Host drives the data bus |
| fl_dq_in | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Several properties are checked on every cycle. The write and output strobes never overlap. The bus is released during reads, and address and data stay still while write-enable is low. The write pulse lasts exactly its parameterised width. The response is a single-cycle pulse, a reserved opcode is answered on the next cycle, and the bus is idle whenever the port is ready. Only the bench scenarios can show that the byte order of each unlock sequence is right and that polling stops on the correct bit-7 value. They also show that the single confirming read after bit 5 is honoured and that the identification bytes arrive in the right halves of `rsp_id`. To do this, a flash model answers the bus with busy, failing and identify behaviour.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_IDENT = 2'd2,
    OP_RSVD  = 2'd3
  } fop_e;

  typedef enum logic [1:0] {AS_U1, AS_U2, AS_TGT} asel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_POLL, S_CONF, S_ID0, S_ID1, S_RST, S_RESP
  } seq_st_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} bus_ph_e;

  localparam logic [7:0] CMD_KEY_A     = 8'hAA;
  localparam logic [7:0] CMD_KEY_B     = 8'h55;
  localparam logic [7:0] CMD_PROG_ARM  = 8'hA0;
  localparam logic [7:0] CMD_ERASE_ARM = 8'h80;
  localparam logic [7:0] CMD_ERASE_ALL = 8'h10;
  localparam logic [7:0] CMD_ID_ENTER  = 8'h90;
  localparam logic [7:0] CMD_RESET     = 8'hF0;

  // number of bus writes in the command phase of each operation
  function automatic logic [2:0] seq_len(fop_e op);
    case (op)
      OP_PROG:  return 3'd4;
      OP_ERASE: return 3'd6;
      OP_IDENT: return 3'd3;
      default:  return 3'd1;
    endcase
  endfunction

  // which address a command step targets: unlock steps repeat with period 3
  function automatic asel_e step_addr(fop_e op, logic [2:0] step);
    if (op == OP_PROG && step == 3'd3) return AS_TGT;
    case (step)
      3'd1, 3'd4: return AS_U2;
      default:    return AS_U1;
    endcase
  endfunction

  function automatic logic [7:0] step_byte(fop_e op, logic [2:0] step, logic [7:0] d);
    if (op == OP_PROG && step == 3'd3) return d;
    case (step)
      3'd0, 3'd3: return CMD_KEY_A;
      3'd1, 3'd4: return CMD_KEY_B;
      default: begin
        case (op)
          OP_PROG:  return CMD_PROG_ARM;
          OP_ERASE: return (step == 3'd2) ? CMD_ERASE_ARM : CMD_ERASE_ALL;
          OP_IDENT: return CMD_ID_ENTER;
          default:  return CMD_RESET;
        endcase
      end
    endcase
  endfunction

  // value bit 7 takes once the operation has finished
  function automatic logic poll_bit(fop_e op, logic [7:0] d);
    return (op == OP_ERASE) ? 1'b1 : d[7];
  endfunction

endpackage

// File: rtl/fseq_bus.sv
module fseq_bus
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int T_SETUP = 2,
  parameter int T_WE    = 3,
  parameter int T_RD    = 3,
  parameter int T_HOLD  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);

  localparam int TMAX = (T_SETUP > T_WE) ?
                        ((T_SETUP > T_RD) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                          : ((T_RD > T_HOLD) ? T_RD : T_HOLD)) :
                        ((T_WE > T_RD) ? ((T_WE > T_HOLD) ? T_WE : T_HOLD)
                                       : ((T_RD > T_HOLD) ? T_RD : T_HOLD));
  localparam int CW = $clog2(TMAX + 1);
  localparam int RW = CW + 1;

  bus_ph_e       ph;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [CW-1:0] strobe_last;
  logic          setup_end, strobe_end, hold_end;

  assign strobe_last = rd_q ? CW'(T_RD - 1) : CW'(T_WE - 1);
  assign setup_end   = (ph == PH_SETUP)  && (cnt == CW'(T_SETUP - 1));
  assign strobe_end  = (ph == PH_STROBE) && (cnt == strobe_last);
  assign hold_end    = (ph == PH_HOLD)   && (cnt == CW'(T_HOLD - 1));
  assign busy        = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      rd_q      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            rd_q      <= rd;
            fl_addr   <= addr;
            fl_dq_out <= rd ? 8'h00 : wdata;
            fl_dq_oe  <= !rd;
            fl_ce_n   <= 1'b0;
            cnt       <= '0;
            ph        <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (setup_end) begin
            cnt     <= '0;
            fl_we_n <= rd_q;
            fl_oe_n <= !rd_q;
            ph      <= PH_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STROBE: begin
          if (strobe_end) begin
            if (rd_q) rdata <= fl_dq_in;
            cnt     <= '0;
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            ph      <= PH_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (hold_end) begin
            cnt      <= '0;
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            done     <= 1'b1;
            ph       <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // length of the current write-enable low run, seen from the pin
  logic [RW-1:0] we_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        we_run <= '0;
    else if (!fl_we_n) we_run <= we_run + 1'b1;
    else               we_run <= '0;
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  p_strobe_in_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (we_run == RW'(T_WE)));
  p_rd_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W    = 17,
  parameter int unsigned UNLOCK_A1 = 'h5555,
  parameter int unsigned UNLOCK_A2 = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [15:0]       rsp_id,
  output logic              bus_start,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_busy,
  input  logic              bus_done,
  input  logic [7:0]        bus_rdata
);

  localparam logic [ADDR_W-1:0] UA1 = ADDR_W'(UNLOCK_A1);
  localparam logic [ADDR_W-1:0] UA2 = ADDR_W'(UNLOCK_A2);

  seq_st_e           state;
  fop_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [2:0]        step_q;
  logic              err_q;
  logic [15:0]       id_q;
  logic              pend;
  fop_e              req_op_e;

  // named events for the assertions and the state machine
  logic accept, seq_last, poll_match, in_bus_state;

  assign req_op_e     = fop_e'(req_op);
  assign req_ready    = (state == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign seq_last     = (step_q == (seq_len(op_q) - 3'd1));
  assign poll_match   = (bus_rdata[7] == poll_bit(op_q, data_q));
  assign in_bus_state = (state != S_IDLE) && (state != S_RESP);
  assign bus_start    = in_bus_state && !pend;
  assign rsp_valid    = (state == S_RESP);
  assign rsp_error    = err_q;
  assign rsp_id       = id_q;

  always_comb begin
    bus_rd    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = 8'h00;
    case (state)
      S_CMD: begin
        case (step_addr(op_q, step_q))
          AS_U1:   bus_addr = UA1;
          AS_U2:   bus_addr = UA2;
          default: bus_addr = addr_q;
        endcase
        bus_wdata = step_byte(op_q, step_q, data_q);
      end
      S_POLL, S_CONF: bus_rd = 1'b1;
      S_ID0: begin
        bus_rd   = 1'b1;
        bus_addr = '0;
      end
      S_ID1: begin
        bus_rd   = 1'b1;
        bus_addr = ADDR_W'(1);
      end
      S_RST: begin
        bus_addr  = UA1;
        bus_wdata = CMD_RESET;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      err_q  <= 1'b0;
      id_q   <= '0;
      pend   <= 1'b0;
    end else begin
      if (bus_start)     pend <= 1'b1;
      else if (bus_done) pend <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q   <= req_op_e;
            addr_q <= req_addr;
            data_q <= req_data;
            step_q <= '0;
            if (req_op_e == OP_RSVD) begin
              err_q <= 1'b1;
              state <= S_RESP;
            end else begin
              err_q <= 1'b0;
              state <= S_CMD;
            end
          end
        end
        S_CMD: begin
          if (bus_done) begin
            if (seq_last) state <= (op_q == OP_IDENT) ? S_ID0 : S_POLL;
            else          step_q <= step_q + 3'd1;
          end
        end
        S_POLL: begin
          if (bus_done) begin
            if (poll_match)        state <= S_RESP;
            else if (bus_rdata[5]) state <= S_CONF;
          end
        end
        S_CONF: begin
          if (bus_done) begin
            if (poll_match) state <= S_RESP;
            else begin
              err_q <= 1'b1;
              state <= S_RST;
            end
          end
        end
        S_ID0: begin
          if (bus_done) begin
            id_q[15:8] <= bus_rdata;
            state      <= S_ID1;
          end
        end
        S_ID1: begin
          if (bus_done) begin
            id_q[7:0] <= bus_rdata;
            state     <= S_RST;
          end
        end
        S_RST:   if (bus_done) state <= S_RESP;
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_busy);
  p_rsvd_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'd3) |=> (rsp_valid && rsp_error));
  p_start_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> !bus_busy);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W    = 17,
  parameter int unsigned UNLOCK_A1 = 'h5555,
  parameter int unsigned UNLOCK_A2 = 'h2AAA,
  parameter int          T_SETUP   = 2,
  parameter int          T_WE      = 3,
  parameter int          T_RD      = 3,
  parameter int          T_HOLD    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [15:0]       rsp_id,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);

  logic              bus_start, bus_rd, bus_busy, bus_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;

  fseq_ctrl #(
    .ADDR_W(ADDR_W), .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_id(rsp_id),
    .bus_start(bus_start), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_busy(bus_busy), .bus_done(bus_done),
    .bus_rdata(bus_rdata)
  );

  fseq_bus #(
    .ADDR_W(ADDR_W), .T_SETUP(T_SETUP), .T_WE(T_WE), .T_RD(T_RD), .T_HOLD(T_HOLD)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .start(bus_start), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .busy(bus_busy), .done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;

  localparam int AW = 17;
  localparam int TS = 2, TW = 3, TR = 3, TH = 1;
  localparam logic [AW-1:0] A1 = 17'h05555, A2 = 17'h02AAA;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          rsp_valid, rsp_error;
  logic [15:0]   rsp_id;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out, fl_dq_in;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  flash_seq #(.ADDR_W(AW), .T_SETUP(TS), .T_WE(TW), .T_RD(TR), .T_HOLD(TH)) u_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_id(rsp_id),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int n_chk = 0, n_fail = 0;

  // ---------------- flash model ----------------
  logic [7:0]    mem [256];
  logic [AW-1:0] log_a [16];
  logic [7:0]    log_d [16];
  int log_n = 0, rd_total = 0, rd_tgt = 0, tim_bad = 0;
  logic [AW-1:0] rd_watch = '0;
  int mst = 0, busy_left = 0, plan_busy = 0;
  bit stuck = 0, dq5_on = 0, plan_dq5 = 0, autosel = 0, bd7 = 0;
  bit prev_we = 1, prev_oe = 1;
  int pre = 0, we_len = 0, oe_len = 0;
  logic [7:0] dq_r;

  always @* begin
    if (busy_left > 0)  dq_r = {~bd7, 1'b0, dq5_on, 5'b0};
    else if (autosel)   dq_r = (fl_addr == 0) ? 8'h37 : (fl_addr == 1) ? 8'hA4 : 8'h00;
    else                dq_r = mem[fl_addr[7:0]];
  end
  assign fl_dq_in = dq_r;

  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d);
    case (mst)
      0: if (a == A1 && d == 8'hAA) mst = 1;
         else if (d == 8'hF0) begin autosel = 0; busy_left = 0; stuck = 0; dq5_on = 0; end
      1: mst = (a == A2 && d == 8'h55) ? 2 : 0;
      2: begin
        if (d == 8'hA0) mst = 3;
        else if (d == 8'h80) mst = 4;
        else begin
          if (d == 8'h90) autosel = 1;
          mst = 0;
        end
      end
      3: begin
        if ((mem[a[7:0]] & d) != d) begin stuck = 1; dq5_on = 1; busy_left = 1; end
        else begin busy_left = plan_busy; dq5_on = plan_dq5; end
        mem[a[7:0]] = mem[a[7:0]] & d;
        bd7 = d[7];
        mst = 0;
      end
      4: mst = (a == A1 && d == 8'hAA) ? 5 : 0;
      5: mst = (a == A2 && d == 8'h55) ? 6 : 0;
      6: begin
        if (d == 8'h10) begin
          for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
          bd7 = 1; busy_left = plan_busy; dq5_on = plan_dq5;
        end
        mst = 0;
      end
      default: mst = 0;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n && !fl_oe_n) tim_bad++;
      if (!prev_we && fl_we_n) begin
        if (!fl_dq_oe || fl_ce_n || pre != TS || we_len != TW) tim_bad++;
        if (log_n < 16) begin log_a[log_n] = fl_addr; log_d[log_n] = fl_dq_out; end
        log_n++;
        model_write(fl_addr, fl_dq_out);
        pre = 0; we_len = 0;
      end
      if (!prev_oe && fl_oe_n) begin
        if (oe_len != TR || pre != TS) tim_bad++;
        rd_total++;
        if (fl_addr == rd_watch) rd_tgt++;
        if (busy_left > 0 && !stuck) busy_left--;
        pre = 0; oe_len = 0;
      end
      if (!fl_we_n) we_len++;
      if (!fl_oe_n) begin oe_len++; if (fl_dq_oe) tim_bad++; end
      if (fl_ce_n) pre = 0;
      else if (fl_we_n && fl_oe_n && prev_we && prev_oe) pre++;
      prev_we = fl_we_n; prev_oe = fl_oe_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int i, input logic [AW-1:0] a, input logic [7:0] d);
    chk(req, $sformatf("write %0d addr", i), longint'(log_a[i]), longint'(a));
    chk(req, $sformatf("write %0d data", i), longint'(log_d[i]), longint'(d));
  endtask

  task automatic clear_log(input logic [AW-1:0] watch);
    log_n = 0; rd_total = 0; rd_tgt = 0; tim_bad = 0; rd_watch = watch;
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                      output logic err, output logic [15:0] id, output int cyc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!rsp_valid && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!rsp_valid) chk("R1", "response timeout", 0, 1);
    err = rsp_error; id = rsp_id;
    @(negedge clk);
    chk("R1", "rsp_valid single pulse", longint'(rsp_valid), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "ready after reset", longint'(req_ready), 1);
    chk("R1", "rsp_valid after reset", longint'(rsp_valid), 0);
    chk("R1", "ce_n after reset", longint'(fl_ce_n), 1);
    chk("R1", "we_n after reset", longint'(fl_we_n), 1);
    chk("R1", "oe_n after reset", longint'(fl_oe_n), 1);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [7:0] d, input int busy);
    logic e; logic [15:0] id; int c;
    clear_log(a); plan_busy = busy; plan_dq5 = 0;
    send(2'd0, a, d, e, id, c);
    chk("R2", "write count", log_n, 4);
    chk_wr("R2", 0, A1, 8'hAA); chk_wr("R2", 1, A2, 8'h55);
    chk_wr("R2", 2, A1, 8'hA0); chk_wr("R2", 3, a, d);
    chk("R6", "error flag", longint'(e), 0);
    chk("R6", "poll reads at target", rd_tgt, busy + 1);
    chk("R6", "no other reads", rd_total, busy + 1);
    chk("R6", "programmed byte", longint'(mem[a[7:0]]), longint'(d));
    chk("R5", "write strobe timing", tim_bad, 0);
    chk("R9", "read strobe timing", tim_bad, 0);
  endtask

  task automatic t_prog_fail();
    logic e; logic [15:0] id; int c;
    clear_log(17'h12); plan_busy = 0; plan_dq5 = 0;
    send(2'd0, 17'h12, 8'hFF, e, id, c);
    chk("R7", "error flag on failure", longint'(e), 1);
    chk("R7", "reads before giving up", rd_tgt, 2);
    chk("R7", "write count incl reset", log_n, 5);
    chk_wr("R7", 4, A1, 8'hF0);
    chk("R7", "cell unchanged", longint'(mem[8'h12]), 8'h5A);
  endtask

  task automatic t_dq5_recover();
    logic e; logic [15:0] id; int c;
    clear_log(17'h30); plan_busy = 1; plan_dq5 = 1;
    send(2'd0, 17'h30, 8'h0F, e, id, c);
    chk("R7", "recovered after confirm read", longint'(e), 0);
    chk("R7", "exactly one confirm read", rd_tgt, 2);
    chk("R7", "no reset write on success", log_n, 4);
    plan_dq5 = 0;
  endtask

  task automatic t_erase();
    logic e; logic [15:0] id; int c;
    clear_log(17'h40); plan_busy = 4; plan_dq5 = 0;
    send(2'd1, 17'h40, 8'h00, e, id, c);
    chk("R3", "write count", log_n, 6);
    chk_wr("R3", 0, A1, 8'hAA); chk_wr("R3", 1, A2, 8'h55); chk_wr("R3", 2, A1, 8'h80);
    chk_wr("R3", 3, A1, 8'hAA); chk_wr("R3", 4, A2, 8'h55); chk_wr("R3", 5, A1, 8'h10);
    chk("R6", "erase poll reads", rd_tgt, 5);
    chk("R6", "erase error flag", longint'(e), 0);
    chk("R3", "array erased", longint'(mem[8'h12]), 8'hFF);
    chk("R5", "timing during erase", tim_bad, 0);
  endtask

  task automatic t_ident();
    logic e; logic [15:0] id; int c;
    clear_log(17'h0); plan_busy = 0;
    send(2'd2, 17'h0, 8'h00, e, id, c);
    chk("R4", "write count", log_n, 4);
    chk_wr("R4", 0, A1, 8'hAA); chk_wr("R4", 1, A2, 8'h55);
    chk_wr("R4", 2, A1, 8'h90); chk_wr("R4", 3, A1, 8'hF0);
    chk("R4", "read count", rd_total, 2);
    chk("R4", "id bytes", longint'(id), 16'h37A4);
    chk("R4", "error flag", longint'(e), 0);
    chk("R4", "device left identify mode", longint'(autosel), 0);
  endtask

  task automatic t_reserved();
    logic e; logic [15:0] id; int c;
    clear_log(17'h0);
    send(2'd3, 17'h55, 8'h11, e, id, c);
    chk("R8", "error flag", longint'(e), 1);
    chk("R8", "response latency", c, 0);
    chk("R8", "no bus writes", log_n, 0);
    chk("R8", "no bus reads", rd_total, 0);
  endtask

  task automatic t_busy_ignore();
    int bad = 0;
    int c = 0;
    clear_log(17'h50); plan_busy = 2; plan_dq5 = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = 2'd0; req_addr = 17'h50; req_data = 8'h44;
    @(negedge clk);
    req_op = 2'd2; req_addr = 17'h60;
    for (int i = 0; i < 12; i++) begin
      if (req_ready) bad++;
      @(negedge clk);
    end
    req_valid = 0;
    while (!rsp_valid && c < 5000) begin @(negedge clk); c++; end
    @(negedge clk);
    chk("R1", "ready low while busy", bad, 0);
    chk("R1", "only one sequence issued", log_n, 4);
    chk("R1", "busy-time request not taken", longint'(mem[8'h60]), 8'hFF);
    chk("R1", "back to idle", longint'(req_ready), 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program(17'h12, 8'h5A, 3);
    t_program(17'h20, 8'hC3, 2);
    t_prog_fail();
    t_dq5_recover();
    t_ident();
    t_reserved();
    t_busy_ignore();
    t_erase();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule